// File: doc/BRIEF.md
# Horizontal Sync Mask and Fill Counter

This block turns a noisy stream of horizontal sync pulses, taken from a composite sync source, into one clean pulse per line. It runs on a reference clock that is a fixed multiple of the line rate, 576 or 448 clocks per line, and counts clocks within the current line. A falling edge on the raw input starts a new line only when it lands inside a narrow window around the expected line length. Edges outside the window are noise or half-line equalizing pulses, and they are dropped. When no edge arrives by the end of the window, the block emits a synthetic pulse and keeps the line grid going.

The cleaned pulse is the feedback input of the frequency loop that generates the reference clock. Two per-line flags describe the line that has just ended: one says the line was closed by a synthetic pulse, the other says rejected edges were seen in it. After reset the block is unlocked, and it takes the first falling edge it sees as the start of a line.

Top module: `hsync_mask_fill`

## Requirements
- R1: After reset the first falling edge of `sync_raw_i` is accepted whatever its timing. Acceptance raises `hsync_o` after the third rising clock edge that follows the input going low, because two synchroniser stages and one edge register lie on the way.
- R2: While locked, let N be the line length and D the distance, in clocks, from the previous line start to a falling edge. The edge is accepted when D lies from N-8 to N+8 inclusive. An accepted edge restarts the line count and starts a new output pulse, with the same three-edge latency as R1.
- R3: While locked, a falling edge outside the window produces no output pulse and leaves the line count running, so a correct edge at distance N afterwards is still accepted.
- R4: When no edge is accepted by distance N+8, a synthetic pulse starts at distance N+8. The count restarts at 8 so that the next window stays centred on the original grid, and a second missing line yields a pulse at distance 2N+8.
- R5: `interp_o` is 1 throughout the line that a synthetic pulse opened, and it returns to 0 when a line is opened by an accepted edge.
- R6: `noise_o` is 1 throughout a line when the line before it contained at least one rejected edge, and 0 when the line before it had none.
- R7: `hsync_o` stays high for exactly 42 clocks when `mode_lo_i` is 0 and for exactly 33 clocks when `mode_lo_i` is 1. The width is chosen at the start of each pulse.
- R8: `mode_lo_i` = 0 sets N = 576, and `mode_lo_i` = 1 sets N = 448. In 448 mode an edge 576 clocks after a line start is handled by R3 and R4, not accepted.
- R9: While `rst_ni` is low, and while unlocked after reset, `hsync_o`, `interp_o` and `noise_o` are 0.
- R10: Equalizing pulses at half-line spacing (distance N/2) are removed, and the full-line edges between them are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, N times the line rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_raw_i | input | 1 | Raw sync from the separator, active low; the falling edge marks a line |
| mode_lo_i | input | 1 | 0: 576 clocks per line, 1: 448 clocks per line |
| hsync_o | output | 1 | Cleaned horizontal sync, active high |
| interp_o | output | 1 | Current line was opened by a synthetic pulse |
| noise_o | output | 1 | Previous line contained rejected edges |

## Verification
An input fall driven at falling clock edge t is accepted at the third rising edge after it, so `hsync_o` and both flags first show the new line at falling edge t+3. A pulse ends at t+3+W, where W is the pulse width. A missing line shows its synthetic pulse at t+N+11, and a second one at t+2N+11. The bench counts falling edges from one point, drives every input and samples every output there, and checks each result at its due edge and at the edge just before. This shows that the result is neither early nor late.

// File: rtl/hsmf_pkg.sv
package hsmf_pkg;
  typedef struct packed {
    logic accept;  // edge taken, new line
    logic interp;  // window expired, synthetic line
    logic reject;  // edge outside window
  } line_evt_t;
endpackage

// File: rtl/hsmf_edge_det.sv
module hsmf_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q[0] <= raw_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/hsmf_line_ctr.sv
module hsmf_line_ctr import hsmf_pkg::*; #(
  parameter int unsigned LINE_HI = 576,
  parameter int unsigned LINE_LO = 448,
  parameter int unsigned WIN     = 8,
  parameter int unsigned CNT_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             mode_lo_i,
  output line_evt_t        evt_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] NOM_HI = CNT_W'(LINE_HI - 1);
  localparam logic [CNT_W-1:0] NOM_LO = CNT_W'(LINE_LO - 1);
  localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(WIN);

  logic [CNT_W-1:0] cnt_q, nom, win_lo, win_hi;
  logic             locked_q, in_win;

  always_comb begin
    nom    = mode_lo_i ? NOM_LO : NOM_HI;
    win_lo = nom - WIN_C;
    win_hi = nom + WIN_C;
    in_win = (cnt_q >= win_lo) && (cnt_q <= win_hi);
  end

  always_comb begin
    evt_o = '0;
    if (!locked_q) begin
      evt_o.accept = fall_i;
    end else if (fall_i && in_win) begin
      evt_o.accept = 1'b1;
    end else begin
      evt_o.reject = fall_i;
      // >= keeps a mode switch past the new window from stalling
      evt_o.interp = (cnt_q >= win_hi);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (evt_o.accept) begin
      cnt_q    <= '0;
      locked_q <= 1'b1;
    end else if (evt_o.interp) begin
      cnt_q <= WIN_C;  // stay on the nominal grid
    end else if (locked_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked_o = locked_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/hsmf_pulse_gen.sv
module hsmf_pulse_gen #(
  parameter int unsigned PW_HI = 42,
  parameter int unsigned PW_LO = 33,
  parameter int unsigned PW_W  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_lo_i,
  output logic pulse_o
);
  localparam logic [PW_W-1:0] LEN_HI_M1 = PW_W'(PW_HI - 1);
  localparam logic [PW_W-1:0] LEN_LO_M1 = PW_W'(PW_LO - 1);

  logic [PW_W-1:0] rem_q;
  logic            act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      rem_q <= mode_lo_i ? LEN_LO_M1 : LEN_HI_M1;
    end else if (act_q) begin
      if (rem_q == '0) act_q <= 1'b0;
      else             rem_q <= rem_q - 1'b1;
    end
  end

  assign pulse_o = act_q;
endmodule

// File: rtl/hsmf_line_flags.sv
module hsmf_line_flags import hsmf_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_evt_t evt_i,
  output logic      interp_o,
  output logic      noise_o
);
  logic acc_q, noise_q, interp_q, boundary;

  assign boundary = evt_i.accept | evt_i.interp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= 1'b0;
      noise_q  <= 1'b0;
      interp_q <= 1'b0;
    end else if (boundary) begin
      noise_q  <= acc_q | evt_i.reject;
      interp_q <= evt_i.interp & ~evt_i.accept;
      acc_q    <= 1'b0;
    end else if (evt_i.reject) begin
      acc_q <= 1'b1;
    end
  end

  assign interp_o = interp_q;
  assign noise_o  = noise_q;
endmodule

// File: rtl/hsync_mask_fill.sv
module hsync_mask_fill import hsmf_pkg::*; #(
  parameter int unsigned LINE_HI     = 576,
  parameter int unsigned LINE_LO     = 448,
  parameter int unsigned WIDTH_HI    = 42,
  parameter int unsigned WIDTH_LO    = 33,
  parameter int unsigned WIN         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_raw_i,
  input  logic mode_lo_i,
  output logic hsync_o,
  output logic interp_o,
  output logic noise_o
);
  localparam int unsigned MAX_LINE = (LINE_HI > LINE_LO) ? LINE_HI : LINE_LO;
  localparam int unsigned MAX_PW   = (WIDTH_HI > WIDTH_LO) ? WIDTH_HI : WIDTH_LO;
  localparam int unsigned CNT_W    = $clog2(MAX_LINE + WIN + 1);
  localparam int unsigned PW_W     = $clog2(MAX_PW + 1);

  logic             fall;
  line_evt_t        evt;
  logic             locked;
  logic [CNT_W-1:0] cnt;

  hsmf_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (sync_raw_i),
    .fall_o(fall)
  );

  hsmf_line_ctr #(
    .LINE_HI(LINE_HI), .LINE_LO(LINE_LO), .WIN(WIN), .CNT_W(CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .mode_lo_i(mode_lo_i),
    .evt_o    (evt),
    .locked_o (locked),
    .cnt_o    (cnt)
  );

  hsmf_pulse_gen #(.PW_HI(WIDTH_HI), .PW_LO(WIDTH_LO), .PW_W(PW_W)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (evt.accept | evt.interp),
    .mode_lo_i(mode_lo_i),
    .pulse_o  (hsync_o)
  );

  hsmf_line_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .interp_o(interp_o),
    .noise_o (noise_o)
  );
endmodule

// File: rtl/hsmf_chk.sv
module hsmf_chk #(
  parameter int unsigned WIDTH_HI = 42,
  parameter int unsigned WIDTH_LO = 33,
  parameter int unsigned WIN      = 8,
  parameter int unsigned CNT_W    = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsync_o,
  input logic             interp_o,
  input logic             noise_o,
  input logic             mode_lo_i,
  input logic             acc_i,
  input logic             itp_i,
  input logic             rej_i,
  input logic             locked_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam int unsigned MAXW = (WIDTH_HI > WIDTH_LO) ? WIDTH_HI : WIDTH_LO;
  localparam int unsigned RW   = $clog2(MAXW + 2);

  logic [RW-1:0] run_q, cap_q;
  logic          started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      cap_q     <= '0;
      started_q <= 1'b0;
    end else if (acc_i | itp_i) begin
      run_q     <= '0;
      cap_q     <= mode_lo_i ? RW'(WIDTH_LO) : RW'(WIDTH_HI);
      started_q <= 1'b1;
    end else if (hsync_o && run_q < cap_q) begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_unlocked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> (!hsync_o && !interp_o && !noise_o));

  assert_rise_on_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> $past(acc_i | itp_i));

  assert_reject_keeps_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && rej_i && !itp_i) |=> (cnt_i == $past(cnt_i) + 1'b1));

  assert_interp_regrid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (itp_i && !acc_i) |=> (cnt_i == CNT_W'(WIN) && hsync_o));

  assert_interp_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (itp_i && !acc_i) |=> interp_o);

  assert_interp_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !interp_o);

  assert_noise_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_i | itp_i) && rej_i) |=> noise_o);

  assert_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (hsync_o == (run_q < cap_q)));
endmodule

bind hsync_mask_fill hsmf_chk #(
  .WIDTH_HI(WIDTH_HI), .WIDTH_LO(WIDTH_LO), .WIN(WIN), .CNT_W(CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hsync_o  (hsync_o),
  .interp_o (interp_o),
  .noise_o  (noise_o),
  .mode_lo_i(mode_lo_i),
  .acc_i    (evt.accept),
  .itp_i    (evt.interp),
  .rej_i    (evt.reject),
  .locked_i (locked),
  .cnt_i    (cnt)
);

// File: tb/hsync_mask_fill_tb_top.sv
`timescale 1ns/1ps
module hsync_mask_fill_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, raw, mode_lo;
  logic hs, itp, nse;

  int checks = 0, fails = 0;
  int ncnt = 0, raise_at = -1, last = 0;
  int n_cur = 576, pw_cur = 42;

  always #2.5 clk = ~clk;

  hsync_mask_fill dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_raw_i(raw), .mode_lo_i(mode_lo),
    .hsync_o(hs), .interp_o(itp), .noise_o(nse)
  );

  task automatic tick();
    @(negedge clk);
    ncnt++;
    if (ncnt == raise_at) raw = 1'b1;
  endtask

  task automatic go(input int k);
    while (ncnt < k) tick();
  endtask

  task automatic fall();
    raw = 1'b0;
    raise_at = ncnt + 2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tag, ncnt, act, exp);
    end
  endtask

  task automatic set_mode(input logic lo);
    mode_lo = lo;
    n_cur  = lo ? 448 : 576;
    pw_cur = lo ? 33 : 42;
  endtask

  // accepted edge at distance g from last line start
  task automatic line_ok(input int g, input string tag);
    int t;
    t = last + g;
    go(t);
    fall();
    go(t + 2); chk({tag, " hsync before due"}, hs, 0);
    go(t + 3); chk({tag, " hsync at due"}, hs, 1);
    chk({tag, " interp after accept (R5)"}, itp, 0);
    last = t;
  endtask

  task automatic t_reset();
    chk("R9 hsync in reset", hs, 0);
    chk("R9 interp in reset", itp, 0);
    chk("R9 noise in reset", nse, 0);
  endtask

  task automatic t_acquire();
    int t;
    go(ncnt + 50);
    chk("R9 hsync while unlocked", hs, 0);
    t = ncnt;
    fall();
    go(t + 2); chk("R1 no pulse before latency", hs, 0);
    go(t + 3); chk("R1 first edge accepted", hs, 1);
    chk("R9 interp after lock", itp, 0);
    go(t + 2 + pw_cur); chk("R7 pulse last high clock", hs, 1);
    go(t + 3 + pw_cur); chk("R7 pulse ended", hs, 0);
    last = t;
  endtask

  task automatic t_window();
    line_ok(n_cur, "R2 nominal");
    line_ok(n_cur - W, "R2 early limit");
    line_ok(n_cur + W, "R2 late limit");
    line_ok(n_cur, "R2 nominal again");
    chk("R6 clean line noise", nse, 0);
  endtask

  task automatic t_reject();
    int t;
    t = last + 100;
    go(t); fall();
    go(t + 3); chk("R3 mid-line edge no pulse", hs, 0);
    chk("R6 noise not yet shown", nse, 0);
    line_ok(n_cur, "R3 count unaffected");
    chk("R6 noise after noisy line", nse, 1);
    t = last + n_cur - W - 1;
    go(t); fall();
    go(t + 3); chk("R3 edge just before window", hs, 0);
    line_ok(n_cur, "R3 resume after near edge");
    chk("R6 noise after near edge", nse, 1);
    line_ok(n_cur, "R6 clean line");
    chk("R6 noise cleared", nse, 0);
  endtask

  task automatic t_equalize();
    for (int i = 0; i < 3; i++) begin
      int t;
      t = last + n_cur / 2;
      go(t); fall();
      go(t + 3); chk("R10 half-line pulse removed", hs, 0);
      line_ok(n_cur, "R10 full-line edge kept");
    end
    line_ok(n_cur, "R10 settle");
    line_ok(n_cur, "R10 settle clean");
    chk("R6 noise after equalizing ends", nse, 0);
  endtask

  task automatic t_interp();
    int t;
    t = last;
    go(t + n_cur + W + 2); chk("R4 no early synthetic pulse", hs, 0);
    go(t + n_cur + W + 3); chk("R4 synthetic pulse", hs, 1);
    chk("R5 interp set", itp, 1);
    go(t + 2 * n_cur + W + 2); chk("R4 second gap before", hs, 0);
    go(t + 2 * n_cur + W + 3); chk("R4 second synthetic on grid", hs, 1);
    chk("R5 interp held", itp, 1);
    last = t + 2 * n_cur;
    line_ok(n_cur, "R4 grid kept after fill");
    chk("R5 interp cleared", itp, 0);
  endtask

  task automatic t_mode();
    int t;
    go(last + pw_cur + 10);
    set_mode(1'b1);
    line_ok(n_cur, "R8 448 nominal");
    go(last + 2 + pw_cur); chk("R7 448 width last high", hs, 1);
    go(last + 3 + pw_cur); chk("R7 448 width ended", hs, 0);
    line_ok(n_cur - W, "R8 448 early limit");
    line_ok(n_cur + W, "R8 448 late limit");
    t = last;
    go(t + 448 + W + 2); chk("R8 448 fill before", hs, 0);
    go(t + 448 + W + 3); chk("R8 448 fill due", hs, 1);
    go(t + 576); fall();
    go(t + 579); chk("R8 576 spacing rejected in 448", hs, 0);
    last = t + 448;
    line_ok(n_cur, "R8 448 grid resume");
    chk("R6 noise from 576 edge", nse, 1);
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0;
    go(ncnt + 3);
    t_reset();
    rst_n = 1'b1;
    go(ncnt + 2);
    t_acquire();
    line_ok(n_cur, "R1 locked after re-acquire");
  endtask

  initial begin
    raw = 1'b1;
    rst_n = 1'b0;
    set_mode(1'b0);
    go(5);
    t_reset();
    rst_n = 1'b1;
    go(ncnt + 2);
    t_acquire();
    t_window();
    t_reject();
    t_equalize();
    t_interp();
    t_mode();
    t_reset_again();
    go(ncnt + 5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule